// File: doc/BRIEF.md
# Debug Address Breakpoint Matcher

The block watches a processor's instruction fetches and data accesses against four breakpoint slots. Each slot has a base address, an enable bit, a 2-bit kind field and a 2-bit span field in a shared control word. A slot of the execute kind raises a request that must be taken before the fetched instruction runs. A slot of a data or I/O kind raises a request that is taken once the instruction has completed. Every hit sets a sticky per-slot bit in a status word, and that bit stays set until software rewrites the status.

Software reaches the registers through a small select/write port. Writes take effect only at kernel level. A guard bit in the control word protects the registers: while it is set, any register access is refused, raises a before-instruction request and sets a dedicated status bit. A pulse marking entry into the debug handler clears the guard so the handler can use the registers. Fetches and data accesses arrive on two separate lanes in the same cycle, so one instruction's execute hit and its data hit can both be presented at once. The execute request then always comes out first.

Top module: `dbg_bp_match`

## Requirements
- R1: After reset all slot addresses, the control word and the status word read 0, and pre_req and post_req are 0.
- R2: With kernel_mode=1 and the guard bit clear, a write (reg_req=1, reg_we=1) stores reg_wdata into the register chosen by reg_sel: 0..3 slot addresses, 4 control word, 5 status word (only bits 0..3 and 13 kept). The value reads back on reg_rdata from the next cycle. reg_rdata follows reg_sel combinationally.
- R3: A register write with kernel_mode=0 is ignored. The register keeps its old value and no request is raised.
- R4: Control layout: slot n is enabled by bit 2n, its kind is at bits 16+4n..17+4n and its span at bits 18+4n..19+4n. Kind 00 (execute) with span 00 hits only on a fetch whose address equals the slot address exactly. pre_req is then 1 after the next rising edge and status bit n is set at that same edge. An execute slot with a non-zero span never hits.
- R5: Span encoding: 00 = 1 byte, 01 = 2, 11 = 4, 10 = 8. The watched range is [addr & ~(len-1), +len). A data access covers [data_addr, data_addr + 2^data_size) with data_size 0..3 = 1, 2, 4, 8 bytes. It hits when the two ranges overlap.
- R6: Kind 01 hits only data writes (data_kind 01), and kind 11 hits reads (00) or writes (01). Neither kind hits I/O accesses (10) or fetches, and execute slots never hit data accesses.
- R7: Kind 10 hits only I/O accesses (data_kind 10), and only while io_dbg_en=1.
- R8: A data or I/O hit makes post_req 1 after the second rising edge following the access. Status bit n is set at that same edge, and pre_req stays 0.
- R9: When a fetch hit and a data hit are presented in the same cycle, pre_req is 1 (post_req 0) after the first edge and post_req is 1 (pre_req 0) after the second.
- R10: While control bit 13 is set, any reg_req raises pre_req after the next edge and sets status bit 13. The write is not performed, and reg_rdata reads 0.
- R11: A handler_entry pulse clears control bit 13 at the next edge. The other control bits are kept.
- R12: Status bits are sticky: they stay set over idle cycles until a status-register write replaces them.
- R13: A slot whose enable bit is 0 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kernel_mode | input | 1 | Register writes allowed when 1 |
| io_dbg_en | input | 1 | Enables I/O-kind matching |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | AW | Start address of the fetched instruction |
| data_valid | input | 1 | Data or I/O access present |
| data_kind | input | 2 | 00 read, 01 write, 10 I/O, 11 none |
| data_addr | input | AW | First byte of the access |
| data_size | input | 2 | log2 of access bytes |
| reg_req | input | 1 | Register access (read or write) |
| reg_we | input | 1 | Access is a write |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | AW | Write data |
| reg_rdata | output | AW | Selected register value |
| handler_entry | input | 1 | Debug handler entry pulse |
| pre_req | output | 1 | Before-instruction debug request |
| post_req | output | 1 | After-instruction debug request |
| dbg_status | output | 16 | Sticky status word |

## Verification
Execute and guard requests are due one rising edge after the stimulus cycle. Data and I/O requests, together with their status bits, are due two edges after it. Register writes are visible from the cycle after the write. The bench drives every stimulus on a falling edge and reads the outputs on the following falling edges. For each data vector it checks that pre_req stays low after the first edge, then checks post_req and the status word after the second. The status word is cleared before each vector, so the expected bits belong to that vector alone.

// File: rtl/dbg_bp_pkg.sv
`timescale 1ns/1ps
package dbg_bp_pkg;
    localparam int NSLOT  = 4;
    localparam int CTL_W  = 32;
    localparam int STAT_W = 16;
    localparam int GD_BIT = 13;
    localparam int KIND_LSB = 16;
    localparam int FLD_STRIDE = 4;
    localparam logic [STAT_W-1:0] STAT_MASK = 16'h200F;
    localparam logic [2:0] SEL_CTL  = 3'd4;
    localparam logic [2:0] SEL_STAT = 3'd5;

    typedef enum logic [1:0] {
        BK_EXEC = 2'b00,
        BK_WR   = 2'b01,
        BK_IO   = 2'b10,
        BK_RW   = 2'b11
    } bp_kind_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'b00,
        AK_WRITE = 2'b01,
        AK_IO    = 2'b10,
        AK_NONE  = 2'b11
    } acc_kind_e;

    function automatic logic [1:0] span_log2(input logic [1:0] span);
        case (span)
            2'b00:   span_log2 = 2'd0;
            2'b01:   span_log2 = 2'd1;
            2'b11:   span_log2 = 2'd2;
            default: span_log2 = 2'd3;
        endcase
    endfunction
endpackage

// File: rtl/dbg_bp_slot.sv
`timescale 1ns/1ps
module dbg_bp_slot
    import dbg_bp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_addr,
    input  logic          slot_en,
    input  logic [1:0]    slot_kind,
    input  logic [1:0]    slot_span,
    input  logic          io_dbg_en,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          data_valid,
    input  logic [1:0]    data_kind,
    input  logic [AW-1:0] data_addr,
    input  logic [1:0]    data_size,
    output logic          exec_hit,
    output logic          data_hit
);
    localparam int EW = AW + 1;

    logic [1:0]    lg;
    logic [EW-1:0] slot_len;
    logic [EW-1:0] slot_lo;
    logic [EW-1:0] slot_hi;
    logic [EW-1:0] acc_lo;
    logic [EW-1:0] acc_hi;
    logic          overlap;
    logic          kind_ok;

    always_comb begin
        lg       = span_log2(slot_span);
        slot_len = EW'(1) << lg;
        slot_lo  = {1'b0, base_addr} & ~(slot_len - EW'(1));
        slot_hi  = slot_lo + slot_len;
        acc_lo   = {1'b0, data_addr};
        acc_hi   = acc_lo + (EW'(1) << data_size);
        overlap  = (acc_lo < slot_hi) && (slot_lo < acc_hi);

        case (slot_kind)
            BK_WR:   kind_ok = (data_kind == AK_WRITE);
            BK_RW:   kind_ok = (data_kind == AK_WRITE) || (data_kind == AK_READ);
            BK_IO:   kind_ok = (data_kind == AK_IO) && io_dbg_en;
            default: kind_ok = 1'b0;
        endcase

        exec_hit = slot_en && (slot_kind == BK_EXEC) && (slot_span == 2'b00)
                   && fetch_valid && (fetch_addr == base_addr);
        data_hit = slot_en && data_valid && kind_ok && overlap;
    end
endmodule

// File: rtl/dbg_bp_regs.sv
`timescale 1ns/1ps
module dbg_bp_regs
    import dbg_bp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     kernel_mode,
    input  logic                     reg_req,
    input  logic                     reg_we,
    input  logic [2:0]               reg_sel,
    input  logic [AW-1:0]            reg_wdata,
    input  logic                     handler_entry,
    input  logic [NSLOT-1:0]         slot_hits,
    output logic [AW-1:0]            reg_rdata,
    output logic [NSLOT-1:0][AW-1:0] slot_addr,
    output logic [CTL_W-1:0]         ctl_word,
    output logic [STAT_W-1:0]        status_word,
    output logic                     gd_trap
);
    localparam int SW = $clog2(NSLOT);

    typedef struct packed {
        logic [NSLOT-1:0][AW-1:0] addr;
        logic [CTL_W-1:0]         ctl;
        logic [STAT_W-1:0]        status;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  wr_ok;

    always_comb begin
        rg_d    = rg_q;
        gd_trap = reg_req && rg_q.ctl[GD_BIT];
        wr_ok   = reg_req && reg_we && kernel_mode && !rg_q.ctl[GD_BIT];
        if (wr_ok) begin
            if (reg_sel < 3'(NSLOT)) begin
                rg_d.addr[reg_sel[SW-1:0]] = reg_wdata;
            end else if (reg_sel == SEL_CTL) begin
                rg_d.ctl = reg_wdata[CTL_W-1:0];
            end else if (reg_sel == SEL_STAT) begin
                rg_d.status = reg_wdata[STAT_W-1:0] & STAT_MASK;
            end
        end
        if (handler_entry) begin
            rg_d.ctl[GD_BIT] = 1'b0;
        end
        rg_d.status = rg_d.status | STAT_W'(slot_hits);
        if (gd_trap) begin
            rg_d.status[GD_BIT] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    always_comb begin
        if (rg_q.ctl[GD_BIT])             reg_rdata = '0;
        else if (reg_sel < 3'(NSLOT))     reg_rdata = rg_q.addr[reg_sel[SW-1:0]];
        else if (reg_sel == SEL_CTL)      reg_rdata = AW'(rg_q.ctl);
        else if (reg_sel == SEL_STAT)     reg_rdata = AW'(rg_q.status);
        else                              reg_rdata = '0;
    end

    assign slot_addr   = rg_q.addr;
    assign ctl_word    = rg_q.ctl;
    assign status_word = rg_q.status;

    // R10: a guarded access always leaves its mark in the status word
    a_r10_guard_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && ctl_word[GD_BIT]) |=> status_word[GD_BIT]);

    // R11: handler entry drops the guard
    a_r11_handler_clears_guard: assert property (@(posedge clk) disable iff (!rst_n)
        handler_entry |=> !ctl_word[GD_BIT]);

    // R3: a user-level control write leaves the control word alone
    a_r3_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && !kernel_mode && reg_sel == SEL_CTL && !handler_entry)
        |=> $stable(ctl_word));
endmodule

// File: rtl/dbg_bp_match.sv
`timescale 1ns/1ps
module dbg_bp_match
    import dbg_bp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kernel_mode,
    input  logic          io_dbg_en,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          data_valid,
    input  logic [1:0]    data_kind,
    input  logic [AW-1:0] data_addr,
    input  logic [1:0]    data_size,
    input  logic          reg_req,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          handler_entry,
    output logic          pre_req,
    output logic          post_req,
    output logic [15:0]   dbg_status
);
    typedef struct packed {
        logic             pre;
        logic             post;
        logic [NSLOT-1:0] dhit;
    } pipe_t;

    pipe_t                    pp_d, pp_q;
    logic [NSLOT-1:0][AW-1:0] slot_addr;
    logic [CTL_W-1:0]         ctl_word;
    logic [STAT_W-1:0]        status_word;
    logic                     gd_trap;
    logic [NSLOT-1:0]         exec_hit;
    logic [NSLOT-1:0]         data_hit;
    logic                     unused_ctl;

    assign unused_ctl = ^ctl_word;

    dbg_bp_regs #(.AW(AW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .kernel_mode   (kernel_mode),
        .reg_req       (reg_req),
        .reg_we        (reg_we),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .handler_entry (handler_entry),
        .slot_hits     (exec_hit | pp_q.dhit),
        .reg_rdata     (reg_rdata),
        .slot_addr     (slot_addr),
        .ctl_word      (ctl_word),
        .status_word   (status_word),
        .gd_trap       (gd_trap)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        dbg_bp_slot #(.AW(AW)) u_slot (
            .base_addr   (slot_addr[i]),
            .slot_en     (ctl_word[2*i]),
            .slot_kind   (ctl_word[KIND_LSB + FLD_STRIDE*i +: 2]),
            .slot_span   (ctl_word[KIND_LSB + 2 + FLD_STRIDE*i +: 2]),
            .io_dbg_en   (io_dbg_en),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .data_valid  (data_valid),
            .data_kind   (data_kind),
            .data_addr   (data_addr),
            .data_size   (data_size),
            .exec_hit    (exec_hit[i]),
            .data_hit    (data_hit[i])
        );
    end

    always_comb begin
        pp_d      = pp_q;
        pp_d.pre  = (|exec_hit) || gd_trap;
        pp_d.dhit = data_hit;
        pp_d.post = |pp_q.dhit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign pre_req    = pp_q.pre;
    assign post_req   = pp_q.post;
    assign dbg_status = status_word;

    // R4: an execute hit needs a fetch in the same cycle
    a_r4_exec_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (|exec_hit) |-> fetch_valid);

    // R9: a before-instruction request comes from a fetch or a register access
    a_r9_pre_source: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req |-> $past(fetch_valid || reg_req));

    // R8: an after-instruction request follows a data access two edges earlier
    a_r8_post_delay: assert property (@(posedge clk) disable iff (!rst_n)
        post_req |-> $past(data_valid, 2));

    // R13: disabled slots never report data hits
    a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_word[0] |-> !data_hit[0] && !exec_hit[0]);
endmodule

// File: tb/dbg_bp_match_tb.sv
`timescale 1ns/1ps
module dbg_bp_match_tb;
    localparam int AW = 32;
    localparam logic [31:0] CTL_BASE = 32'hABD00055;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          kernel_mode = 1'b1;
    logic          io_dbg_en = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          data_valid = 1'b0;
    logic [1:0]    data_kind = 2'b11;
    logic [AW-1:0] data_addr = '0;
    logic [1:0]    data_size = '0;
    logic          reg_req = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          handler_entry = 1'b0;
    logic          pre_req;
    logic          post_req;
    logic [15:0]   dbg_status;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dbg_bp_match #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .kernel_mode(kernel_mode), .io_dbg_en(io_dbg_en),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .data_valid(data_valid), .data_kind(data_kind), .data_addr(data_addr),
        .data_size(data_size), .reg_req(reg_req), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .handler_entry(handler_entry),
        .pre_req(pre_req), .post_req(post_req), .dbg_status(dbg_status)
    );

    // io_en, kind, addr, size, exp_post, exp_status
    typedef logic [53:0] vec_t;
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        {1'b1, 2'd1, 32'h2004, 2'd0, 1'b1, 16'h0002},
        {1'b1, 2'd0, 32'h2004, 2'd0, 1'b0, 16'h0000},
        {1'b1, 2'd1, 32'h2002, 2'd2, 1'b1, 16'h0002},
        {1'b1, 2'd1, 32'h2000, 2'd2, 1'b0, 16'h0000},
        {1'b1, 2'd1, 32'h2007, 2'd0, 1'b1, 16'h0002},
        {1'b1, 2'd1, 32'h2008, 2'd0, 1'b0, 16'h0000},
        {1'b1, 2'd0, 32'h300F, 2'd0, 1'b1, 16'h0004},
        {1'b1, 2'd1, 32'h3000, 2'd3, 1'b0, 16'h0000},
        {1'b1, 2'd0, 32'h3006, 2'd1, 1'b0, 16'h0000},
        {1'b1, 2'd0, 32'h3006, 2'd2, 1'b1, 16'h0004},
        {1'b1, 2'd2, 32'h0027, 2'd0, 1'b1, 16'h0008},
        {1'b1, 2'd2, 32'h0028, 2'd0, 1'b0, 16'h0000},
        {1'b0, 2'd2, 32'h0020, 2'd0, 1'b0, 16'h0000},
        {1'b1, 2'd0, 32'h0020, 2'd0, 1'b0, 16'h0000},
        {1'b1, 2'd2, 32'h2004, 2'd0, 1'b0, 16'h0000},
        {1'b1, 2'd1, 32'h1000, 2'd0, 1'b0, 16'h0000},
        {1'b1, 2'd1, 32'h1FFF, 2'd1, 1'b0, 16'h0000},
        {1'b1, 2'd1, 32'h2003, 2'd1, 1'b1, 16'h0002}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [31:0] val);
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [2:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
    endtask

    task automatic data_acc(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
        data_valid = 1'b1; data_kind = k; data_addr = a; data_size = s;
        @(negedge clk);
        data_valid = 1'b0; data_kind = 2'b11;
    endtask

    task automatic fetch_acc(input logic [31:0] a);
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pre", 32'(pre_req), 0);
        check("R1 post", 32'(post_req), 0);
        check("R1 status", 32'(dbg_status), 0);
        read_reg(3'd4, rv); check("R1 ctl", rv, 0);
        read_reg(3'd1, rv); check("R1 addr1", rv, 0);

        // R2 program slots
        reg_write(3'd0, 32'h1000);
        reg_write(3'd1, 32'h2004);
        reg_write(3'd2, 32'h3009);
        reg_write(3'd3, 32'h0020);
        reg_write(3'd4, CTL_BASE);
        read_reg(3'd2, rv); check("R2 addr2", rv, 32'h3009);
        read_reg(3'd4, rv); check("R2 ctl", rv, CTL_BASE);
        reg_write(3'd5, 32'hFFFF);
        read_reg(3'd5, rv); check("R2 status mask", rv, 32'h200F);
        reg_write(3'd5, 32'h0);

        // R3 user-level write ignored
        kernel_mode = 1'b0;
        reg_write(3'd0, 32'hDEAD);
        check("R3 no request", 32'(pre_req), 0);
        kernel_mode = 1'b1;
        read_reg(3'd0, rv); check("R3 addr0 kept", rv, 32'h1000);

        // R5 R6 R7 R8 vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            io_dbg_en = v[53];
            reg_write(3'd5, 32'h0);
            data_acc(v[52:51], v[50:19], v[18:17]);
            check($sformatf("R8 vec%0d pre stays low", i), 32'(pre_req), 0);
            @(negedge clk);
            check($sformatf("R5/R6/R7 vec%0d post", i), 32'(post_req), 32'(v[16]));
            check($sformatf("R8 vec%0d status", i), 32'(dbg_status), 32'(v[15:0]));
        end

        // R12 sticky status
        repeat (3) @(negedge clk);
        check("R12 sticky", 32'(dbg_status), 32'h0002);
        reg_write(3'd5, 32'h0);
        check("R12 cleared", 32'(dbg_status), 0);

        // R4 execute matching
        fetch_acc(32'h1000);
        check("R4 exact pre", 32'(pre_req), 1);
        check("R4 status", 32'(dbg_status), 32'h0001);
        @(negedge clk);
        check("R4 no post", 32'(post_req), 0);
        reg_write(3'd5, 32'h0);
        fetch_acc(32'h1001);
        check("R4 inside no pre", 32'(pre_req), 0);
        fetch_acc(32'h2004);
        check("R6 fetch on write slot", 32'(pre_req), 0);
        reg_write(3'd4, CTL_BASE | 32'h0004_0000);
        fetch_acc(32'h1000);
        check("R4 nonzero span no pre", 32'(pre_req), 0);
        reg_write(3'd4, CTL_BASE);
        check("R4 status still 0", 32'(dbg_status), 0);

        // R9 ordering
        fetch_valid = 1'b1; fetch_addr = 32'h1000;
        data_valid = 1'b1; data_kind = 2'd1; data_addr = 32'h2004; data_size = 2'd0;
        @(negedge clk);
        fetch_valid = 1'b0; data_valid = 1'b0; data_kind = 2'b11;
        check("R9 pre first", 32'(pre_req), 1);
        check("R9 post not yet", 32'(post_req), 0);
        @(negedge clk);
        check("R9 pre done", 32'(pre_req), 0);
        check("R9 post second", 32'(post_req), 1);
        check("R9 status", 32'(dbg_status), 32'h0003);
        reg_write(3'd5, 32'h0);

        // R13 disabled slot
        reg_write(3'd4, CTL_BASE & ~32'h4);
        data_acc(2'd1, 32'h2004, 2'd0);
        @(negedge clk);
        check("R13 post", 32'(post_req), 0);
        check("R13 status", 32'(dbg_status), 0);
        reg_write(3'd4, CTL_BASE);

        // R10 guard
        reg_write(3'd4, CTL_BASE | 32'h2000);
        check("R10 no trap on setting", 32'(pre_req), 0);
        reg_write(3'd0, 32'h5555);
        check("R10 pre", 32'(pre_req), 1);
        check("R10 status", 32'(dbg_status), 32'h2000);
        read_reg(3'd0, rv); check("R10 rdata blocked", rv, 0);

        // R11 handler entry
        handler_entry = 1'b1;
        @(negedge clk);
        handler_entry = 1'b0;
        read_reg(3'd4, rv); check("R11 guard cleared", rv, CTL_BASE);
        read_reg(3'd0, rv); check("R10 write suppressed", rv, 32'h1000);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule